// File: doc/BRIEF.md
# Inter-processor interrupt mailbox

This block lets the cores of a multi-core system interrupt one another through ordinary memory writes. Every core owns a small register window with a control word and a status word. To signal another core, software writes its own control word with a send flag, a destination core index and a 16-bit payload. The destination's status word then records the sender's index and the payload and sets a pending flag. That flag drives the destination's interrupt line as a level.

The receiving core reads its status word to learn who called and what was sent. It then writes an acknowledge flag to its own control word, which drops its line. There is one message slot per destination. A newer send to a core that is still pending replaces the sender and payload. The block has no interrupt inputs. The bus port is a plain 32-bit single-cycle write port with a combinational read path.

Top module: `ipi_mailbox`

## Requirements
- R1: Core k's window is 8 bytes wide. Its control word sits at byte address k*8 (address bit 2 = 0) and its status word at k*8+4 (address bit 2 = 1). Address bits 1:0 are ignored. Writes to an address whose core index is NUM_CORES or above have no effect, and reads there return zero.
- R2: A control write by core N with bit 30 (send) set and a destination index d in bits 29:16 below NUM_CORES updates core d's status word at the next clock edge. Bit 30 (pending) becomes 1, bits 29:16 become N, and bits 15:0 take the written bits 15:0.
- R3: Bit k of irq equals core k's pending flag. It rises in the cycle after the sending write and stays high across idle cycles until acknowledged.
- R4: A control write with bit 31 (acknowledge) set clears the writer's own pending flag and leaves its source and payload fields unchanged.
- R5: When acknowledge and send are set in the same write, the acknowledge is applied first. A core that sends to itself in that write therefore ends with pending set and the new source and payload.
- R6: A send whose destination index is NUM_CORES or above changes no status word and no irq bit.
- R7: A send to a core that is already pending overwrites source and payload, and pending stays set.
- R8: Reading a control word returns zero. Bit 31 of every read word is zero. Read data follows the address in the same cycle.
- R9: Writes to a status word are ignored.
- R10: Reset clears every pending flag, source and payload, so all irq bits are 0 and all status words read zero.
- R11: A control write with neither bit 31 nor bit 30 set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CORES | Level interrupt, one bit per core |

## Verification
A write takes effect at the clock edge on which bus_we is sampled. The changed status word and irq bit can be seen from the next cycle. Read data is combinational, so a status word can be read in any cycle with no added latency. The bench drives each write during one cycle. In the following cycle it turns the port into a read of the status word being checked, then samples bus_rdata and irq shortly after the falling edge. Every check therefore lands one edge after its stimulus.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq
);
  localparam int IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int SLOT_W = ADDR_W - 3;

  logic [NUM_CORES-1:0] pend_q;
  logic [IDX_W-1:0]     src_q  [NUM_CORES];
  logic [15:0]          data_q [NUM_CORES];

  logic [SLOT_W-1:0] slot;
  logic [13:0]       dst;
  logic              slot_ok, dst_ok, ctrl_wr, gen_wr, ack_wr;

  assign slot    = bus_addr[ADDR_W-1:3];
  assign dst     = bus_wdata[29:16];
  assign slot_ok = 32'(slot) < NUM_CORES;
  assign dst_ok  = 32'(dst) < NUM_CORES;
  assign ctrl_wr = bus_we & slot_ok & ~bus_addr[2];
  assign gen_wr  = ctrl_wr & bus_wdata[30] & dst_ok;
  assign ack_wr  = ctrl_wr & bus_wdata[31];

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
        src_q[k]  <= '0;
        data_q[k] <= '0;
      end else begin
        if (ack_wr && slot == SLOT_W'(k)) pend_q[k] <= 1'b0;
        if (gen_wr && dst == 14'(k)) begin
          pend_q[k] <= 1'b1;
          src_q[k]  <= slot[IDX_W-1:0];
          data_q[k] <= bus_wdata[15:0];
        end
      end
    end
  end

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = slot[IDX_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (slot_ok && bus_addr[2])
      bus_rdata = {1'b0, pend_q[rd_idx], 14'(src_q[rd_idx]), data_q[rd_idx]};
  end

  assign irq = pend_q;
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CORES-1:0] irq
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [ADDR_W-4:0] c_slot;
  logic [13:0]       c_dst;
  logic              c_ctrl, c_gen, c_ack;

  assign c_slot = bus_addr[ADDR_W-1:3];
  assign c_dst  = bus_wdata[29:16];
  assign c_ctrl = bus_we && !bus_addr[2] && (32'(c_slot) < NUM_CORES);
  assign c_gen  = c_ctrl && bus_wdata[30] && (32'(c_dst) < NUM_CORES);
  assign c_ack  = c_ctrl && bus_wdata[31];

  logic             p_gen, p_clr, p_quiet;
  logic [IDX_W-1:0] p_dst, p_core;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_gen   <= 1'b0;
      p_clr   <= 1'b0;
      p_quiet <= 1'b0;
      p_dst   <= '0;
      p_core  <= '0;
    end else begin
      p_gen   <= c_gen;
      p_clr   <= c_ack && !(c_gen && c_dst == 14'(c_slot));
      p_quiet <= !c_gen && !c_ack;
      p_dst   <= c_dst[IDX_W-1:0];
      p_core  <= c_slot[IDX_W-1:0];
    end
  end

  // R2, R3, R5, R7
  assert_deliver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    p_gen |-> irq[p_dst]);
  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p_clr |-> !irq[p_core]);
  // R6, R9, R11
  assert_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_quiet |-> $stable(irq));
  assert_ctrl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[2] |-> bus_rdata == 32'h0);
  assert_reserved_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[31]);
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb_top;
  localparam int NC = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_mailbox #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {write addr, write data, read addr, expected read data, expected irq}
  localparam int NV = 11;
  localparam logic [83:0] VEC [NV] = '{
    {8'h00, 32'h4002_1234, 8'h14, 32'h4000_1234, 4'b0100}, // R2 core0->core2
    {8'h18, 32'h4000_ABCD, 8'h04, 32'h4003_ABCD, 4'b0101}, // R2 core3->core0
    {8'h08, 32'h4002_5555, 8'h14, 32'h4001_5555, 4'b0101}, // R7 overwrite
    {8'h10, 32'h8000_0000, 8'h14, 32'h0001_5555, 4'b0001}, // R4 ack
    {8'h00, 32'h4004_7777, 8'h04, 32'h4003_ABCD, 4'b0001}, // R6 bad dst
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000, 4'b0001}, // R9 status write
    {8'h00, 32'hC000_2222, 8'h04, 32'h4000_2222, 4'b0001}, // R5 ack+self send
    {8'h08, 32'h0003_9999, 8'h1C, 32'h0000_0000, 4'b0001}, // R11 no flags
    {8'h18, 32'hC001_4444, 8'h0C, 32'h4003_4444, 4'b0011}, // R5 ack+send other
    {8'h20, 32'h4001_0000, 8'h0C, 32'h4003_4444, 4'b0011}, // R1 core4 window
    {8'h0A, 32'h8000_0000, 8'h0C, 32'h0003_4444, 4'b0001}  // R1 low bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset irq", 32'(irq), 32'h0);
    read_check("R10 reset status", 8'h04, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][83:76], VEC[i][75:44]);
      read_check($sformatf("R2/R3 vector %0d rdata", i), VEC[i][43:36], VEC[i][35:4]);
      check($sformatf("R3 vector %0d irq", i), 32'(irq), 32'(VEC[i][3:0]));
    end

    read_check("R8 ctrl read zero", 8'h00, 32'h0);
    read_check("R8 ctrl read zero core3", 8'h18, 32'h0);
    read_check("R1 out of range read", 8'h24, 32'h0);
    repeat (5) @(negedge clk);
    #1;
    check("R3 irq held while idle", 32'(irq), 32'h1);
    read_check("R8 status bit31 zero", 8'h04, 32'h4000_2222);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset clears irq", 32'(irq), 32'h0);
    read_check("R10 reset clears core0", 8'h04, 32'h0);
    read_check("R10 reset clears core1", 8'h0C, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule